// File: doc/BRIEF.md
# Packed Double-to-Int32 Converter

This block converts two IEEE-754 double-precision values, packed side by side in one 128-bit source word, into two signed 32-bit integers. Both conversions run in parallel in combinational lanes, and one registered stage commits the packed result one clock after the input is accepted. The caller provides a 2-bit rounding-mode input and a mask bit for the invalid-operation condition.

Any lane whose value cannot be represented returns the integer indefinite pattern `0x80000000`; it does not saturate. A lane cannot be represented when it is a NaN, an infinity, or a value outside the signed 32-bit range after rounding. Two sticky flags gather the invalid and precision conditions until reset. When the invalid condition is unmasked and either lane is invalid, the block raises a one-cycle fault in place of result-valid, and the result register keeps its previous value.

Output sequencing is a three-state machine:
- `ST_IDLE` means no result this cycle.
- `ST_RESULT` means a committed result, with `out_valid` high.
- `ST_FAULT` means the operation trapped, with `fault` high.

From any state, an accepted input moves the machine to `ST_FAULT` if an unmasked lane is invalid, and to `ST_RESULT` otherwise. A cycle with no accepted input returns it to `ST_IDLE`.

Top module: `pdi_convert`

## Requirements
- R1: Lane 0 reads source bits 63:0 and writes result bits 31:0. Lane 1 reads source bits 127:64 and writes result bits 63:32. Each value is two's complement.
- R2: Result bits 127:64 always read zero.
- R3: `rnd_mode` selects the rounding of a value that is not exact: 00 = nearest with ties to even, 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero. Exact values are unaffected by the mode.
- R4: A value whose rounded result lies outside [-2^31, 2^31-1] is invalid. When masked, that lane returns 0x80000000. A value that rounds to exactly -2^31 is valid and is not flagged.
- R5: NaN and infinity inputs (exponent field all ones) are invalid and return 0x80000000 when masked.
- R6: Zero and denormal inputs convert to 0, with two exceptions: a positive nonzero denormal gives 1 under mode 10, and a negative nonzero denormal gives -1 under mode 01. Any nonzero denormal sets the precision flag.
- R7: The precision flag is set when any valid lane discards a nonzero fraction. An invalid lane never contributes to the precision flag.
- R8: `inv_flag` and `prec_flag` are sticky. They OR together the conditions of both lanes over all accepted operations until reset.
- R9: When `inv_mask`=0 and either lane is invalid, `fault` pulses for one cycle and `out_valid` stays low. In that case the result holds its previous value, the precision flag is not updated, and `inv_flag` is set.
- R10: The result and `out_valid` appear exactly one clock after `in_valid`. Neither `out_valid` nor `fault` is asserted without an accepted input in the previous cycle.
- R11: Synchronous reset clears `out_valid`, `fault`, both flags and the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Source word is presented this cycle |
| src | input | 128 | Two packed doubles |
| rnd_mode | input | 2 | Rounding selection (R3 encoding) |
| inv_mask | input | 1 | 1 = invalid is masked (substitute value), 0 = fault |
| result | output | 128 | Two packed int32 values, upper half zero |
| out_valid | output | 1 | Result committed this cycle |
| inv_flag | output | 1 | Sticky invalid-operation flag |
| prec_flag | output | 1 | Sticky inexact flag |
| fault | output | 1 | Unmasked invalid operation trapped |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume that reset is applied on the first edge, so no `$past` term ever looks at a state from before reset. The bench drives inputs only on falling edges, holds `in_valid` low during every reset, and issues operations one per cycle, either back to back or with idle cycles between them. A behavioural model built on real-number floor and ceiling computes each lane's expected integer and flags, and it is compared with every output after every edge.

// File: rtl/pdi_pkg.sv
package pdi_pkg;
    localparam int FP_W   = 64;
    localparam int EXP_W  = 11;
    localparam int FRAC_W = 52;
    localparam int BIAS   = 1023;
    localparam int INT_W  = 32;

    typedef enum logic [1:0] {
        RND_NEAR = 2'b00,
        RND_DOWN = 2'b01,
        RND_UP   = 2'b10,
        RND_ZERO = 2'b11
    } rnd_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_RESULT = 2'b01,
        ST_FAULT  = 2'b10
    } out_state_e;

    typedef struct packed {
        logic [INT_W-1:0] value;
        logic             invalid;
        logic             inexact;
    } lane_res_t;
endpackage

// File: rtl/pdi_lane.sv
module pdi_lane
    import pdi_pkg::*;
(
    input  logic [FP_W-1:0] op_i,
    input  rnd_mode_e       mode_i,
    output lane_res_t       res_o
);
    localparam logic [INT_W:0] POS_LIMIT = 33'h0_7FFF_FFFF;
    localparam logic [INT_W:0] NEG_LIMIT = 33'h0_8000_0000;

    logic                   sgn;
    logic [EXP_W-1:0]       bexp;
    logic [FRAC_W-1:0]      frac;
    logic [FRAC_W:0]        sig;
    logic signed [EXP_W+1:0] uexp;
    logic [5:0]             rsh;
    logic [FRAC_W:0]        keep_mask;
    logic [FRAC_W:0]        rem;
    logic [INT_W:0]         ipart;
    logic [INT_W:0]         mag;
    logic [INT_W:0]         neg;
    logic                   guard, sticky, special, over, incr, bad;

    assign sgn  = op_i[FP_W-1];
    assign bexp = op_i[FP_W-2:FRAC_W];
    assign frac = op_i[FRAC_W-1:0];
    assign sig  = {1'b1, frac};
    assign uexp = $signed({2'b00, bexp}) - $signed((EXP_W+2)'(BIAS));

    // Split the significand into integer part, guard bit and sticky bits.
    always_comb begin
        rsh       = '0;
        keep_mask = '0;
        rem       = '0;
        ipart     = '0;
        guard     = 1'b0;
        sticky    = 1'b0;
        special   = 1'b0;
        over      = 1'b0;
        if (bexp == '1) begin
            special = 1'b1;
        end else if (bexp == '0) begin
            sticky = |frac;
        end else if (uexp > 13'sd31) begin
            over = 1'b1;
        end else if (uexp >= 13'sd0) begin
            rsh       = 6'(13'sd52 - uexp);
            keep_mask = (53'd1 << rsh) - 53'd1;
            ipart     = 33'(sig >> rsh);
            rem       = sig & keep_mask;
            guard     = |(rem & ~(keep_mask >> 1));
            sticky    = |(rem & (keep_mask >> 1));
        end else if (uexp == -13'sd1) begin
            guard  = 1'b1;
            sticky = |frac;
        end else begin
            sticky = 1'b1;
        end
    end

    always_comb begin
        unique case (mode_i)
            RND_NEAR: incr = guard & (sticky | ipart[0]);
            RND_DOWN: incr = sgn & (guard | sticky);
            RND_UP:   incr = ~sgn & (guard | sticky);
            RND_ZERO: incr = 1'b0;
            default:  incr = 1'b0;
        endcase
    end

    assign mag = ipart + {{INT_W{1'b0}}, incr};
    assign neg = '0 - mag;
    assign bad = special | over | (sgn ? (mag > NEG_LIMIT) : (mag > POS_LIMIT));

    assign res_o.invalid = bad;
    assign res_o.inexact = ~bad & (guard | sticky);
    assign res_o.value   = bad ? 32'h8000_0000 : (sgn ? neg[INT_W-1:0] : mag[INT_W-1:0]);

    // R4: an invalid lane always carries the indefinite pattern
    always_comb begin
        if (res_o.invalid) a_indef_r4: assert (res_o.value == 32'h8000_0000);
    end
endmodule

// File: rtl/pdi_ctrl.sv
module pdi_ctrl
    import pdi_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid_i,
    input  logic                   inv_mask_i,
    input  logic [LANES*INT_W-1:0] lane_val_i,
    input  logic [LANES-1:0]       lane_inv_i,
    input  logic [LANES-1:0]       lane_inx_i,
    output logic [LANES*INT_W-1:0] res_o,
    output logic                   out_valid_o,
    output logic                   fault_o,
    output logic                   inv_flag_o,
    output logic                   prec_flag_o
);
    out_state_e state_q, state_d;
    logic any_inv, fault_now;

    assign any_inv   = |lane_inv_i;
    assign fault_now = any_inv & ~inv_mask_i;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (in_valid_i) state_d = fault_now ? ST_FAULT : ST_RESULT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o       <= '0;
            inv_flag_o  <= 1'b0;
            prec_flag_o <= 1'b0;
        end else if (in_valid_i) begin
            inv_flag_o <= inv_flag_o | any_inv;
            if (!fault_now) begin
                res_o       <= lane_val_i;
                prec_flag_o <= prec_flag_o | (|lane_inx_i);
            end
        end
    end

    always_comb begin
        out_valid_o = 1'b0;
        fault_o     = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: out_valid_o = 1'b1;
            ST_FAULT:  fault_o     = 1'b1;
            default:   ;
        endcase
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid_i && !fault_now) |=> out_valid_o);
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(in_valid_i) |-> (!out_valid_o && !fault_o));
    p_fault_unmasked_r9: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> ($past(in_valid_i && !inv_mask_i) && inv_flag_o));
    p_inv_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        inv_flag_o |=> inv_flag_o);
    p_prec_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        prec_flag_o |=> prec_flag_o);
    p_fault_holds_r9: assert property (@(posedge clk) disable iff (rst)
        fault_o |-> $stable(res_o));
endmodule

// File: rtl/pdi_convert.sv
module pdi_convert
    import pdi_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [LANES*FP_W-1:0]   src,
    input  logic [1:0]              rnd_mode,
    input  logic                    inv_mask,
    output logic [LANES*FP_W-1:0]   result,
    output logic                    out_valid,
    output logic                    inv_flag,
    output logic                    prec_flag,
    output logic                    fault
);
    localparam int LOW_W = LANES * INT_W;
    localparam int PAD_W = LANES * FP_W - LOW_W;

    logic [LOW_W-1:0] lane_val;
    logic [LANES-1:0] lane_inv;
    logic [LANES-1:0] lane_inx;
    logic [LOW_W-1:0] res_low;
    rnd_mode_e        mode;

    assign mode = rnd_mode_e'(rnd_mode);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_res_t lr;
        pdi_lane u_lane (
            .op_i   (src[g*FP_W +: FP_W]),
            .mode_i (mode),
            .res_o  (lr)
        );
        assign lane_val[g*INT_W +: INT_W] = lr.value;
        assign lane_inv[g]                = lr.invalid;
        assign lane_inx[g]                = lr.inexact;
    end

    pdi_ctrl #(.LANES(LANES)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .inv_mask_i  (inv_mask),
        .lane_val_i  (lane_val),
        .lane_inv_i  (lane_inv),
        .lane_inx_i  (lane_inx),
        .res_o       (res_low),
        .out_valid_o (out_valid),
        .fault_o     (fault),
        .inv_flag_o  (inv_flag),
        .prec_flag_o (prec_flag)
    );

    assign result = {{PAD_W{1'b0}}, res_low};
endmodule

// File: tb/pdi_convert_test.sv
module pdi_convert_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src = '0;
    logic [1:0]   rnd_mode = 2'b00;
    logic         inv_mask = 1'b1;
    logic [127:0] result;
    logic         out_valid, inv_flag, prec_flag, fault;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [127:0] e_res;
    bit e_valid, e_fault, e_inv, e_prec;

    always #5 clk = ~clk;

    pdi_convert uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src),
        .rnd_mode(rnd_mode), .inv_mask(inv_mask), .result(result),
        .out_valid(out_valid), .inv_flag(inv_flag), .prec_flag(prec_flag),
        .fault(fault)
    );

    function automatic logic [63:0] d(input real r);
        return $realtobits(r);
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
        end
    endtask

    task automatic model_lane(input logic [63:0] x, input logic [1:0] rm,
                              output logic [31:0] v, output bit inv, output bit inx);
        real r, q, fl, diff;
        inv = 0; inx = 0; v = '0;
        if (x[62:52] == 11'h7FF) begin
            inv = 1; v = 32'h8000_0000;
            return;
        end
        r = $bitstoreal(x);
        if (r >= 4503599627370496.0 || r <= -4503599627370496.0) q = r;
        else begin
            case (rm)
                2'b00: begin
                    fl = $floor(r); diff = r - fl;
                    if (diff > 0.5) q = fl + 1.0;
                    else if (diff < 0.5) q = fl;
                    else q = ($floor(fl / 2.0) * 2.0 == fl) ? fl : fl + 1.0;
                end
                2'b01: q = $floor(r);
                2'b10: q = $ceil(r);
                default: q = (r < 0.0) ? $ceil(r) : $floor(r);
            endcase
        end
        if (q > 2147483647.0 || q < -2147483648.0) begin
            inv = 1; v = 32'h8000_0000;
        end else begin
            v = 32'(longint'(q));
            inx = (q != r);
        end
    endtask

    task automatic compare(input string tag);
        check(tag, "result", result, e_res);
        check(tag, "out_valid", {127'd0, out_valid}, {127'd0, e_valid});
        check(tag, "fault", {127'd0, fault}, {127'd0, e_fault});
        check(tag, "inv_flag", {127'd0, inv_flag}, {127'd0, e_inv});
        check(tag, "prec_flag", {127'd0, prec_flag}, {127'd0, e_prec});
    endtask

    task automatic do_reset(input string tag);
        rst = 1; in_valid = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        e_res = '0; e_valid = 0; e_fault = 0; e_inv = 0; e_prec = 0;
        compare(tag);
    endtask

    task automatic step(input string tag, input bit vld, input logic [63:0] l1,
                        input logic [63:0] l0, input logic [1:0] rm, input bit msk);
        logic [31:0] v0, v1;
        bit i0, i1, x0, x1, flt;
        in_valid = vld; src = {l1, l0}; rnd_mode = rm; inv_mask = msk;
        e_valid = 0; e_fault = 0;
        if (vld) begin
            model_lane(l0, rm, v0, i0, x0);
            model_lane(l1, rm, v1, i1, x1);
            flt = (i0 | i1) & ~msk;
            e_inv = e_inv | i0 | i1;
            if (flt) e_fault = 1;
            else begin
                e_valid = 1;
                e_prec  = e_prec | x0 | x1;
                e_res   = {64'd0, v1, v0};
            end
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 0;
        compare(tag);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R11 reset state");
        // R1 R2 R10: exact values, lane placement
        step("R1 exact", 1, d(2.0), d(1.0), 2'b00, 1);
        step("R1 placement", 1, d(-7.0), d(5.0), 2'b11, 1);
        step("R10 idle", 0, '0, '0, 2'b00, 1);
        step("R2 high zero", 1, d(-1.0), d(-2147483000.0), 2'b00, 1);
        // R3 rounding modes on ties
        do_reset("R11 reset");
        step("R3 nearest", 1, d(-2.5), d(2.5), 2'b00, 1);
        step("R3 down", 1, d(-2.5), d(2.5), 2'b01, 1);
        step("R3 up", 1, d(-2.5), d(2.5), 2'b10, 1);
        step("R3 zero", 1, d(-2.5), d(2.5), 2'b11, 1);
        step("R3 nearest odd", 1, d(-0.5), d(1.5), 2'b00, 1);
        step("R3 fraction", 1, d(-3.7), d(0.75), 2'b00, 1);
        // R4 range edges
        do_reset("R11 reset");
        step("R4 min in range", 1, d(-2147483648.0), d(2147483647.0), 2'b00, 1);
        step("R4 max inexact R7", 1, d(2147483647.4), d(-2147483648.4), 2'b00, 1);
        do_reset("R11 reset");
        step("R4 overflow", 1, d(2147483648.0), d(1.0), 2'b00, 1);
        do_reset("R11 reset");
        step("R4 tie overflow R7", 1, d(2147483647.5), d(3.0), 2'b00, 1);
        do_reset("R11 reset");
        step("R4 neg overflow", 1, d(-2147483649.0), d(-1e20), 2'b11, 1);
        // R5 NaN / infinity
        do_reset("R11 reset");
        step("R5 nan inf", 1, 64'h7FF8_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b00, 1);
        // R6 zero and denormal
        do_reset("R11 reset");
        step("R6 zero", 1, 64'h8000_0000_0000_0000, 64'h0, 2'b10, 1);
        step("R6 denorm near", 1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b00, 1);
        step("R6 denorm up", 1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b10, 1);
        step("R6 denorm down", 1, 64'h8000_0000_0000_0001, 64'h0000_0000_0000_0001, 2'b01, 1);
        // R7 invalid lane contributes no precision
        do_reset("R11 reset");
        step("R7 invalid only", 1, d(1e30), d(4.0), 2'b00, 1);
        // R9 unmasked fault
        do_reset("R11 reset");
        step("R9 setup", 1, d(9.0), d(8.0), 2'b00, 0);
        step("R9 fault", 1, 64'h7FF8_0000_0000_0001, d(0.3), 2'b00, 0);
        step("R10 after fault", 0, '0, '0, 2'b00, 0);
        step("R9 fault overflow", 1, d(0.5), d(-5e9), 2'b11, 0);
        // R8 stickiness across clean ops
        step("R8 sticky", 1, d(6.0), d(7.25), 2'b00, 1);
        step("R8 sticky hold", 1, d(6.0), d(7.0), 2'b00, 1);
        // mixed patterns
        do_reset("R11 reset");
        for (int i = 0; i < 48; i++) begin
            real a, b;
            a = (((i * 37) % 101) - 50) * 0.75 + 0.125 * i;
            b = -a * 13.3 + ((i * 7) % 5) * 0.5;
            step("R3 sweep", (i % 5) != 4, d(b), d(a), 2'(i % 4), 1);
        end
        do_reset("R11 final reset");
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule